// File: doc/BRIEF.md
# USB Microframe Index Counter

This block holds the 14-bit frame/microframe index of a dual-role USB controller. The low three bits count the eight 125 µs microframes inside a 1 ms frame, and the upper eleven bits hold the frame number. In host mode the index advances by one on every microframe tick while the controller runs. Its upper bits are also sent out as the frame number for outgoing start-of-frame packets. A programmable list-size code chooses how many index bits address the periodic schedule list. The block outputs that list-entry offset and pulses a rollover flag each time the selected field wraps.

In device mode the index is read-only from software. It follows the frame numbers carried by received start-of-frame tokens. A token that carries a new frame number reloads the frame field and clears the microframe count. A token that repeats the current frame number advances the microframe count instead. Software can load the index only in host mode, while the controller is halted, and only with a full-width write.

Top module: `usb_uframe_index`

## Requirements
- R1: While rst_ni is low and after reset, index_o is 0 and rollover_o is 0.
- R2: In host mode (host_mode_i=1), with run_i=1 and uf_tick_i=1 at a clock edge, index_o becomes the old value plus one, modulo 2^14. With run_i=0, uf_tick_i has no effect.
- R3: In host mode with run_i=0, wr_en_i=1 and wr_be_i=4'b1111, index_o takes wr_data_i[13:0] at the next edge. wr_data_i[31:14] is discarded.
- R4: A write with any wr_be_i other than 4'b1111 leaves index_o unchanged.
- R5: A write while run_i=1 leaves index_o unchanged.
- R6: In device mode (host_mode_i=0), writes leave index_o unchanged.
- R7: The list-size code list_size_i = c (0..7) selects 1024 >> c list entries, so N = 12 - c. list_offset_o equals index_o[N:3], zero-extended to 10 bits.
- R8: In host mode, rollover_o is high for exactly the one cycle after a counting tick that found index_o[N:0] all ones. At every other time it is 0.
- R9: In device mode, when sof_valid_i=1 and sof_frame_i differs from index_o[13:3], index_o becomes {sof_frame_i, 3'b000}.
- R10: In device mode, when sof_valid_i=1 and sof_frame_i equals index_o[13:3], index_o[2:0] increments modulo 8 and index_o[13:3] is kept.
- R11: In device mode, uf_tick_i has no effect on index_o or rollover_o.
- R12: sof_frame_o always equals index_o[13:3], which is the frame number used for transmitted SOF packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_data_i | input | 32 | Software write data |
| wr_en_i | input | 1 | Software write strobe |
| wr_be_i | input | 4 | Byte enables of the write |
| run_i | input | 1 | Controller running (1) or halted (0) |
| host_mode_i | input | 1 | 1 = host mode, 0 = device mode |
| list_size_i | input | 3 | Periodic list size code |
| uf_tick_i | input | 1 | Microframe tick, one cycle per 125 µs |
| sof_valid_i | input | 1 | A start-of-frame token was received |
| sof_frame_i | input | 11 | Frame number of the received token |
| index_o | output | 14 | Frame/microframe index |
| list_offset_o | output | 10 | Periodic list entry selected by the index |
| sof_frame_o | output | 11 | Frame number for transmitted SOF packets |
| rollover_o | output | 1 | One-cycle pulse when the selected list field wraps |

## Verification
The bench uses the default parameters: a 14-bit index, an 11-bit frame field and eight list-size codes. At these values the whole state space is small enough to sweep. One run steps through all 16384 host index values at the smallest list size and checks the full 14-bit wrap. Every list-size code is driven across its own wrap boundary. In device mode, all 2048 frame numbers are sent both as new frames and as repeated frames.

// File: rtl/usb_uframe_pkg.sv
package usb_uframe_pkg;
  localparam int unsigned UF_W        = 3;
  localparam int unsigned FRM_W       = 11;
  localparam int unsigned IDX_W       = UF_W + FRM_W;
  localparam int unsigned LIST_LOG2   = 10;
  localparam int unsigned SIZE_W      = 3;
  localparam int unsigned NUM_SIZES   = 1 << SIZE_W;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned BE_W        = DATA_W / 8;

  typedef logic [IDX_W-1:0] idx_t;
  typedef logic [FRM_W-1:0] frm_t;
endpackage

// File: rtl/uframe_wr_gate.sv
module uframe_wr_gate #(
  parameter int unsigned BE_W = 4
) (
  input  logic            wr_en_i,
  input  logic [BE_W-1:0] wr_be_i,
  input  logic            run_i,
  input  logic            host_mode_i,
  output logic            wr_accept_o
);
  // only a full-width write, host mode, halted
  assign wr_accept_o = wr_en_i && (&wr_be_i) && !run_i && host_mode_i;
endmodule

// File: rtl/uframe_list_sel.sv
module uframe_list_sel
  import usb_uframe_pkg::*;
(
  input  idx_t                 idx_i,
  input  logic [SIZE_W-1:0]    size_i,
  output logic [LIST_LOG2-1:0] offset_o,
  output idx_t                 wrap_mask_o
);
  idx_t mask_tab [NUM_SIZES];

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_mask
    localparam int unsigned LOW_BITS = LIST_LOG2 + UF_W - g;
    assign mask_tab[g] = idx_t'((64'd1 << LOW_BITS) - 64'd1);
  end

  idx_t masked;
  always_comb begin
    wrap_mask_o = mask_tab[size_i];
    masked      = idx_i & wrap_mask_o;
    offset_o    = masked[UF_W +: LIST_LOG2];
  end
endmodule

// File: rtl/uframe_idx_core.sv
module uframe_idx_core
  import usb_uframe_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_accept_i,
  input  idx_t wr_value_i,
  input  logic host_mode_i,
  input  logic run_i,
  input  logic uf_tick_i,
  input  logic sof_valid_i,
  input  frm_t sof_frame_i,
  input  idx_t wrap_mask_i,
  output idx_t idx_o,
  output logic rollover_o
);
  idx_t idx_q, idx_d;
  logic roll_d, roll_q;
  logic host_step;
  frm_t cur_frm;
  logic [UF_W-1:0] cur_uf;

  assign cur_frm   = idx_q[IDX_W-1:UF_W];
  assign cur_uf    = idx_q[UF_W-1:0];
  assign host_step = host_mode_i && run_i && uf_tick_i;

  always_comb begin
    idx_d  = idx_q;
    roll_d = 1'b0;
    if (host_mode_i) begin
      if (wr_accept_i) begin
        idx_d = wr_value_i;
      end else if (host_step) begin
        idx_d  = idx_q + idx_t'(1);
        roll_d = ((idx_q & wrap_mask_i) == wrap_mask_i);
      end
    end else if (sof_valid_i) begin
      if (sof_frame_i != cur_frm) idx_d = {sof_frame_i, {UF_W{1'b0}}};
      else                        idx_d = {cur_frm, cur_uf + 1'b1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      roll_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      roll_q <= roll_d;
    end
  end

  assign idx_o      = idx_q;
  assign rollover_o = roll_q;
endmodule

// File: rtl/usb_uframe_index.sv
module usb_uframe_index
  import usb_uframe_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic                 wr_en_i,
  input  logic [BE_W-1:0]      wr_be_i,
  input  logic                 run_i,
  input  logic                 host_mode_i,
  input  logic [SIZE_W-1:0]    list_size_i,
  input  logic                 uf_tick_i,
  input  logic                 sof_valid_i,
  input  logic [FRM_W-1:0]     sof_frame_i,
  output logic [IDX_W-1:0]     index_o,
  output logic [LIST_LOG2-1:0] list_offset_o,
  output logic [FRM_W-1:0]     sof_frame_o,
  output logic                 rollover_o
);
  logic wr_accept;
  idx_t wrap_mask;
  idx_t idx;

  uframe_wr_gate #(.BE_W(BE_W)) u_wr_gate (
    .wr_en_i     (wr_en_i),
    .wr_be_i     (wr_be_i),
    .run_i       (run_i),
    .host_mode_i (host_mode_i),
    .wr_accept_o (wr_accept)
  );

  uframe_list_sel u_list_sel (
    .idx_i       (idx),
    .size_i      (list_size_i),
    .offset_o    (list_offset_o),
    .wrap_mask_o (wrap_mask)
  );

  uframe_idx_core u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_accept_i (wr_accept),
    .wr_value_i  (wr_data_i[IDX_W-1:0]),
    .host_mode_i (host_mode_i),
    .run_i       (run_i),
    .uf_tick_i   (uf_tick_i),
    .sof_valid_i (sof_valid_i),
    .sof_frame_i (sof_frame_i),
    .wrap_mask_i (wrap_mask),
    .idx_o       (idx),
    .rollover_o  (rollover_o)
  );

  assign index_o     = idx;
  assign sof_frame_o = idx[IDX_W-1:UF_W];
endmodule

// File: rtl/usb_uframe_index_chk.sv
module usb_uframe_index_chk
  import usb_uframe_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [DATA_W-1:0]    wr_data_i,
  input logic                 wr_en_i,
  input logic [BE_W-1:0]      wr_be_i,
  input logic                 run_i,
  input logic                 host_mode_i,
  input logic [SIZE_W-1:0]    list_size_i,
  input logic                 uf_tick_i,
  input logic                 sof_valid_i,
  input logic [FRM_W-1:0]     sof_frame_i,
  input logic [IDX_W-1:0]     index_o,
  input logic [LIST_LOG2-1:0] list_offset_o,
  input logic [FRM_W-1:0]     sof_frame_o,
  input logic                 rollover_o
);
  assert_reset_idx_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (index_o == '0 && !rollover_o));

  assert_host_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && run_i && uf_tick_i) |=> index_o == IDX_W'($past(index_o) + 1'b1));

  assert_wr_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && !run_i && wr_en_i && (&wr_be_i)) |=> index_o == $past(wr_data_i[IDX_W-1:0]));

  // covers R4 and R2 halted ticks
  assert_halt_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && !run_i && !(wr_en_i && (&wr_be_i))) |=> $stable(index_o));

  assert_run_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && run_i && !uf_tick_i) |=> $stable(index_o));

  // covers R6 and R11
  assert_dev_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && !sof_valid_i) |=> $stable(index_o));

  assert_offset_range_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, list_offset_o} < (11'd1024 >> list_size_i));

  assert_roll_src_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rollover_o |-> $past(host_mode_i && run_i && uf_tick_i));

  assert_dev_new_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && sof_valid_i && sof_frame_i != index_o[IDX_W-1:UF_W])
      |=> index_o == {$past(sof_frame_i), {UF_W{1'b0}}});

  assert_dev_same_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && sof_valid_i && sof_frame_i == index_o[IDX_W-1:UF_W])
      |=> (index_o[IDX_W-1:UF_W] == $past(sof_frame_i) &&
           index_o[UF_W-1:0] == UF_W'($past(index_o[UF_W-1:0]) + 1'b1)));

  assert_sof_frame_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_frame_o == index_o[IDX_W-1:UF_W]);
endmodule

bind usb_uframe_index usb_uframe_index_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_data_i     (wr_data_i),
  .wr_en_i       (wr_en_i),
  .wr_be_i       (wr_be_i),
  .run_i         (run_i),
  .host_mode_i   (host_mode_i),
  .list_size_i   (list_size_i),
  .uf_tick_i     (uf_tick_i),
  .sof_valid_i   (sof_valid_i),
  .sof_frame_i   (sof_frame_i),
  .index_o       (index_o),
  .list_offset_o (list_offset_o),
  .sof_frame_o   (sof_frame_o),
  .rollover_o    (rollover_o)
);

// File: tb/usb_uframe_index_tb_top.sv
module usb_uframe_index_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_be_i = '0;
  logic        run_i = 1'b0;
  logic        host_mode_i = 1'b1;
  logic [2:0]  list_size_i = '0;
  logic        uf_tick_i = 1'b0;
  logic        sof_valid_i = 1'b0;
  logic [10:0] sof_frame_i = '0;
  logic [13:0] index_o;
  logic [9:0]  list_offset_o;
  logic [10:0] sof_frame_o;
  logic        rollover_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [13:0] exp_idx = '0;
  logic        exp_roll = 1'b0;

  always #10 clk_i = ~clk_i;

  usb_uframe_index dut_i (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] mask_of(int code);
    return 14'((1 << (13 - code)) - 1);
  endfunction

  task automatic chk_all(string req);
    chk(req, int'(index_o), int'(exp_idx));
    chk({req, "/R7"}, int'(list_offset_o), int'((exp_idx & mask_of(int'(list_size_i))) >> 3));
    chk({req, "/R8"}, int'(rollover_o), int'(exp_roll));
    chk({req, "/R12"}, int'(sof_frame_o), int'(exp_idx[13:3]));
  endtask

  task automatic wr(logic [31:0] d, logic [3:0] be);
    @(negedge clk_i);
    wr_data_i = d; wr_be_i = be; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_be_i = '0;
    exp_roll = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk_i);
    uf_tick_i = 1'b1;
    @(negedge clk_i);
    uf_tick_i = 1'b0;
    if (host_mode_i && run_i) begin
      exp_roll = ((exp_idx & mask_of(int'(list_size_i))) == mask_of(int'(list_size_i)));
      exp_idx  = exp_idx + 14'd1;
    end else exp_roll = 1'b0;
  endtask

  task automatic sof(logic [10:0] f);
    @(negedge clk_i);
    sof_valid_i = 1'b1; sof_frame_i = f;
    @(negedge clk_i);
    sof_valid_i = 1'b0;
    if (f != exp_idx[13:3]) exp_idx = {f, 3'b000};
    else exp_idx = {f, 3'(exp_idx[2:0] + 3'd1)};
    exp_roll = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset idx", int'(index_o), 0);
    chk("R1 reset roll", int'(rollover_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R1 after reset");

    // host writes
    wr(32'hABCD_1234, 4'hF); exp_idx = 14'h1234;
    chk_all("R3 full write");
    wr(32'h0000_0055, 4'b0111);
    chk_all("R4 partial write");
    wr(32'h0000_0055, 4'b1000);
    chk_all("R4 partial write hi");
    tick();
    chk_all("R2 halted tick");
    run_i = 1'b1;
    wr(32'h0000_0077, 4'hF);
    chk_all("R5 write while run");

    // each list size across its wrap
    for (int c = 0; c < 8; c++) begin
      logic [13:0] v;
      run_i = 1'b0;
      list_size_i = 3'(c);
      v = (14'h2AAA & ~mask_of(c)) | (mask_of(c) - 14'd2);
      wr({18'h0, v}, 4'hF); exp_idx = v;
      chk_all("R3 preset");
      run_i = 1'b1;
      for (int k = 0; k < 4; k++) begin
        tick();
        chk_all("R2 tick near wrap");
      end
      @(negedge clk_i); exp_roll = 1'b0;
      chk_all("R8 pulse ends");
    end

    // full sweep at smallest list
    run_i = 1'b0; list_size_i = 3'd7;
    wr(32'h0, 4'hF); exp_idx = '0;
    run_i = 1'b1;
    for (int k = 0; k < 16384; k++) begin
      tick();
      chk_all("R2 sweep");
    end
    chk("R2 14-bit wrap", int'(index_o), 0);

    // device mode
    run_i = 1'b1; host_mode_i = 1'b0;
    tick();
    chk_all("R11 tick ignored");
    run_i = 1'b0;
    wr(32'h0000_1555, 4'hF);
    chk_all("R6 device write");
    for (int f = 0; f < 2048; f++) begin
      sof(11'(2047 - f));
      chk_all("R9 new frame");
      sof(11'(2047 - f));
      chk_all("R10 repeat frame");
    end
    sof(11'h123);
    for (int k = 0; k < 8; k++) begin
      sof(11'h123);
      chk_all("R10 uframe wrap");
    end
    run_i = 1'b1;
    tick();
    chk_all("R11 tick ignored run");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule